// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM's contents alive by spreading the required number of refresh operations evenly over the retention period. An internal interval divider, sized from the clock frequency, the retention time and the number of rows, produces one refresh credit per interval. While any credit is outstanding, the block asks the access sequencer for the memory bus. Once the bus is granted, it drives the strobes itself for one complete refresh cycle.

By default a refresh is CAS-before-RAS: the column strobe falls first, the row strobe follows, and the write enable stays high the whole time so that the device never enters its test mode. If the mode input is set when the grant is taken, the block instead performs a RAS-only refresh. In that mode the column strobe stays high and the address bus carries a row number from an internal counter, which advances after each completed RAS-only cycle.

Credits that the sequencer has not yet served are counted up to a fixed limit. When the count reaches that limit, an urgent flag is raised so that the sequencer can give refresh priority over host traffic.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and directly after it, req_o, urgent_o, own_o and done_o are 0, backlog_o is 0, and ras_n_o, cas_n_o and we_n_o are 1.
- R2: One refresh credit is created every INTERVAL cycles, where INTERVAL = CLK_KHZ*RETENTION_MS / 2^ROW_W (1562 with the defaults). The first credit makes req_o high exactly INTERVAL rising edges after reset is released, and successive credits are INTERVAL cycles apart.
- R3: req_o is high while the block is idle and backlog_o is nonzero. A rising edge that sees req_o and gnt_i both high starts a refresh: from the next cycle own_o is 1 and req_o is 0 until the refresh ends.
- R4: A CAS-before-RAS refresh (ras_only_i=0 at the grant) runs as follows. First cas_n_o=0 and ras_n_o=1 for SETUP_CYC cycles. Then both strobes are 0 for RAS_CYC cycles. Then both are 1 for RP_CYC cycles. we_n_o is 1 throughout and addr_o is 0.
- R5: A RAS-only refresh (ras_only_i=1 at the grant) has the same phase lengths as R4, but cas_n_o stays 1 in every phase, and addr_o carries the current row count during all cycles in which own_o is 1.
- R6: The row counter is ROW_W bits wide and starts at 0. It increments by one after each completed RAS-only refresh, and a CAS-before-RAS refresh leaves it unchanged.
- R7: backlog_o counts credits not yet granted. It saturates at MAX_BACKLOG (8), and credits that arrive while it is full are dropped.
- R8: urgent_o is 1 exactly when backlog_o equals MAX_BACKLOG.
- R9: Each grant retires one credit in the grant cycle. When credits remain, req_o is high again in the first idle cycle after own_o falls, so a backlog drains in back-to-back refreshes down to 0.
- R10: done_o pulses for one cycle, in the last precharge cycle of each refresh, and own_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only_i | input | 1 | Selects a RAS-only refresh for the refresh granted in this cycle |
| gnt_i | input | 1 | Bus grant from the access sequencer |
| req_o | output | 1 | Bus request, held while credits are pending and the block is idle |
| urgent_o | output | 1 | Backlog is at its limit; refresh should take priority |
| own_o | output | 1 | The block is driving the DRAM strobes |
| done_o | output | 1 | Last cycle of a refresh |
| backlog_o | output | $clog2(MAX_BACKLOG+1) | Number of pending refresh credits |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low (always high) |
| addr_o | output | ROW_W | Row address for RAS-only refresh, 0 otherwise |

## Verification
The bench measures the exact cycle of the first request and the spacing between credits. An off-by-one in the divider's terminal count would move that request by one cycle. A scoreboard compares every owned cycle against the expected strobe pattern. A design that lowered RAS first, let CAS drop in RAS-only mode, shortened a phase or drove write enable low would mismatch within the refresh. Interleaving CAS-before-RAS cycles between RAS-only cycles exposes a row counter that advances on the wrong kind of refresh. Finally, the bench holds off the grant well past the limit, then drains the backlog. A counter that wraps instead of saturating, an urgent flag that lags by one credit, or a request that is not re-raised between back-to-back refreshes would each be flagged.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_PRE    = 2'd3
   } seq_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/ref_interval_div.sv
module ref_interval_div #(
   parameter int INTERVAL_CYC = 1562
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CNT_W = $clog2(INTERVAL_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

   if (INTERVAL_CYC < 2) begin : g_bad_interval
      $error("ref_interval_div: INTERVAL_CYC must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
   parameter int MAX_PEND = 8,
   parameter int BL_W     = $clog2(MAX_PEND + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            take_i,
   output logic [BL_W-1:0] count_o,
   output logic            full_o
);
   localparam logic [BL_W-1:0] LIMIT = BL_W'(MAX_PEND);

   if (MAX_PEND < 1) begin : g_bad_pend
      $error("ref_backlog: MAX_PEND must be at least 1");
   end

   logic [BL_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case ({tick_i, take_i})
            2'b10:   if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
            2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign count_o = cnt_q;
   assign full_o  = (cnt_q == LIMIT);
endmodule

// File: rtl/ref_strobe_seq.sv
module ref_strobe_seq
   import ref_sched_pkg::*;
#(
   parameter int SETUP_CYC = 1,
   parameter int RAS_CYC   = 4,
   parameter int RP_CYC    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic mode_ror_i,
   output logic busy_o,
   output logic done_o,
   output logic ror_o,
   output logic ras_n_o,
   output logic cas_n_o
);
   localparam int MAXC  = max3(SETUP_CYC, RAS_CYC, RP_CYC);
   localparam int TMR_W = $clog2(MAXC + 1);
   localparam logic [TMR_W-1:0] LD_SETUP = TMR_W'(SETUP_CYC - 1);
   localparam logic [TMR_W-1:0] LD_RAS   = TMR_W'(RAS_CYC - 1);
   localparam logic [TMR_W-1:0] LD_RP    = TMR_W'(RP_CYC - 1);

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("ref_strobe_seq: SETUP_CYC must be at least 1");
   end
   if (RAS_CYC < 2 || RP_CYC < 2) begin : g_bad_phase
      $error("ref_strobe_seq: RAS_CYC and RP_CYC must be at least 2");
   end

   seq_state_t       state_q;
   logic [TMR_W-1:0] tmr_q;
   logic             ror_q;
   logic             last;

   assign last = (tmr_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tmr_q   <= '0;
         ror_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_SETUP;
                  tmr_q   <= LD_SETUP;
                  ror_q   <= mode_ror_i;
               end
            end
            ST_SETUP: begin
               if (last) begin
                  state_q <= ST_ACTIVE;
                  tmr_q   <= LD_RAS;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            ST_ACTIVE: begin
               if (last) begin
                  state_q <= ST_PRE;
                  tmr_q   <= LD_RP;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            default: begin
               if (last) begin
                  state_q <= ST_IDLE;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
         endcase
      end
   end

   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = (state_q == ST_PRE) && last;
   assign ror_o   = ror_q;
   assign ras_n_o = (state_q != ST_ACTIVE);
   assign cas_n_o = ror_q || !((state_q == ST_SETUP) || (state_q == ST_ACTIVE));
endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
   parameter int ROW_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [ROW_W-1:0] row_o
);
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
      end else if (inc_i) begin
         row_q <= row_q + 1'b1;
      end
   end

   assign row_o = row_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int CLK_KHZ        = 100000,
   parameter int RETENTION_MS   = 128,
   parameter int ROW_W          = 13,
   parameter int MAX_BACKLOG    = 8,
   parameter int SETUP_CYC      = 1,
   parameter int RAS_CYC        = 4,
   parameter int RP_CYC         = 3,
   parameter int TRC_CYC        = 7,
   parameter bit ALLOW_RAS_ONLY = 1'b1,
   localparam int BL_W          = $clog2(MAX_BACKLOG + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_only_i,
   input  logic             gnt_i,
   output logic             req_o,
   output logic             urgent_o,
   output logic             own_o,
   output logic             done_o,
   output logic [BL_W-1:0]  backlog_o,
   output logic             ras_n_o,
   output logic             cas_n_o,
   output logic             we_n_o,
   output logic [ROW_W-1:0] addr_o
);
   localparam longint ROWS         = longint'(1) << ROW_W;
   localparam int     INTERVAL_CYC = int'((longint'(CLK_KHZ) * RETENTION_MS) / ROWS);
   localparam int     SEQ_CYC      = SETUP_CYC + RAS_CYC + RP_CYC;

   if (RAS_CYC + RP_CYC < TRC_CYC) begin : g_bad_trc
      $error("dram_refresh_sched: RAS_CYC + RP_CYC shorter than the random cycle time");
   end
   if (INTERVAL_CYC <= SEQ_CYC) begin : g_bad_rate
      $error("dram_refresh_sched: refresh interval not longer than one refresh cycle");
   end
   if (ROW_W < 2 || ROW_W > 16) begin : g_bad_row
      $error("dram_refresh_sched: ROW_W out of range");
   end

   logic             tick;
   logic             start;
   logic             busy;
   logic             ror;
   logic             mode_sel;
   logic             pend_full;
   logic [BL_W-1:0]  pend;
   logic [ROW_W-1:0] row;

   assign mode_sel = ras_only_i & ALLOW_RAS_ONLY;
   assign req_o    = !busy && (pend != '0);
   assign start    = req_o && gnt_i;

   ref_interval_div #(.INTERVAL_CYC(INTERVAL_CYC)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   ref_backlog #(.MAX_PEND(MAX_BACKLOG), .BL_W(BL_W)) u_backlog (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .take_i  (start),
      .count_o (pend),
      .full_o  (pend_full)
   );

   ref_strobe_seq #(.SETUP_CYC(SETUP_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .mode_ror_i (mode_sel),
      .busy_o     (busy),
      .done_o     (done_o),
      .ror_o      (ror),
      .ras_n_o    (ras_n_o),
      .cas_n_o    (cas_n_o)
   );

   if (ALLOW_RAS_ONLY) begin : g_row
      ref_row_ctr #(.ROW_W(ROW_W)) u_row (
         .clk   (clk),
         .rst_n (rst_n),
         .inc_i (done_o & ror),
         .row_o (row)
      );
   end else begin : g_norow
      assign row = '0;
   end

   assign urgent_o  = pend_full;
   assign backlog_o = pend;
   assign own_o     = busy;
   assign we_n_o    = 1'b1;
   assign addr_o    = (busy && ror) ? row : '0;
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
   parameter int ROW_W       = 13,
   parameter int BL_W        = 4,
   parameter int MAX_BACKLOG = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_o,
   input logic             urgent_o,
   input logic             own_o,
   input logic             done_o,
   input logic [BL_W-1:0]  backlog_o,
   input logic             ras_n_o,
   input logic             cas_n_o,
   input logic [ROW_W-1:0] addr_o
);
   // R3
   no_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      own_o |-> !req_o);

   // R4
   cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n_o) |-> ras_n_o);

   // R4
   cbr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n_o |-> (addr_o == '0));

   // R4
   ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |=> !ras_n_o);

   // R4
   rp_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_o) |=> ras_n_o);

   // R7
   backlog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(backlog_o) <= MAX_BACKLOG);

   // R7
   backlog_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(backlog_o) <= int'($past(backlog_o)) + 1);

   // R8
   urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      urgent_o |-> (req_o || own_o));

   // R10
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !own_o);
endmodule

bind dram_refresh_sched ref_sched_chk #(
   .ROW_W       (ROW_W),
   .BL_W        (BL_W),
   .MAX_BACKLOG (MAX_BACKLOG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_o     (req_o),
   .urgent_o  (urgent_o),
   .own_o     (own_o),
   .done_o    (done_o),
   .backlog_o (backlog_o),
   .ras_n_o   (ras_n_o),
   .cas_n_o   (cas_n_o),
   .addr_o    (addr_o)
);

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
   localparam int ROW_W    = 13;
   localparam int MAXB     = 8;
   localparam int INTERVAL = 1562;
   localparam int BL_W     = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_only = 1'b0;
   logic gnt = 1'b0;
   logic req, urgent, own, done;
   logic [BL_W-1:0]  backlog;
   logic ras_n, cas_n, we_n;
   logic [ROW_W-1:0] addr;

   dram_refresh_sched dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ras_only_i (ras_only),
      .gnt_i      (gnt),
      .req_o      (req),
      .urgent_o   (urgent),
      .own_o      (own),
      .done_o     (done),
      .backlog_o  (backlog),
      .ras_n_o    (ras_n),
      .cas_n_o    (cas_n),
      .we_n_o     (we_n),
      .addr_o     (addr)
   );

   always #5 clk = ~clk;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;
   int  model_row = 0;
   logic [ROW_W+3:0] exp_q[$];  // {ras_n, cas_n, we_n, done, addr}

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Driver side: expected strobe pattern for one refresh
   task automatic push_seq(input bit ror);
      logic [ROW_W-1:0] a;
      a = ror ? ROW_W'(model_row) : '0;
      exp_q.push_back({1'b1, ror, 1'b1, 1'b0, a});
      for (int k = 0; k < 4; k++) exp_q.push_back({1'b0, ror, 1'b1, 1'b0, a});
      for (int k = 0; k < 3; k++) exp_q.push_back({1'b1, 1'b1, 1'b1, (k == 2), a});
      if (ror) model_row = (model_row + 1) % (1 << ROW_W);
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wait_req();
      while (!req) step();
   endtask

   task automatic wait_idle();
      while (own) step();
   endtask

   task automatic wait_backlog(input int n);
      while (int'(backlog) != n) step();
   endtask

   task automatic do_grant(input bit ror);
      ras_only = ror;
      gnt = 1'b1;
      push_seq(ror);
      step();
      gnt = 1'b0;
      ras_only = 1'b0;
      chk("R3 own after grant", own, 1);
      chk("R3 req low while owning", req, 0);
   endtask

   // Monitor side: compare every owned cycle with the queue
   always @(negedge clk) begin
      if (rst_n && !finished && own) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R4 R5 unexpected bus cycle: actual owned expected idle");
         end else begin
            logic [ROW_W+3:0] item;
            item = exp_q.pop_front();
            chk("R4 R5 R10 strobe pattern", {ras_n, cas_n, we_n, done, addr}, item);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      time t1, t2;
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1 req", req, 0);
      chk("R1 own", own, 0);
      chk("R1 urgent", urgent, 0);
      chk("R1 backlog", backlog, 0);
      chk("R1 strobes", {ras_n, cas_n, we_n}, 3'b111);
      rst_n = 1'b1;

      // R2 first request after exactly INTERVAL edges
      for (int i = 1; i <= INTERVAL; i++) begin
         step();
         if (i == INTERVAL - 1) chk("R2 no early request", req, 0);
      end
      chk("R2 request at interval", req, 1);
      chk("R7 one credit", backlog, 1);
      t1 = $time;

      // R4 CAS-before-RAS refresh
      do_grant(1'b0);
      chk("R9 credit retired", backlog, 0);
      wait_idle();
      chk("R10 idle after done", own, 0);
      chk("R9 no request when empty", req, 0);

      // R2 spacing of credits
      wait_req();
      t2 = $time;
      chk("R2 credit spacing", 64'((t2 - t1) / 10), INTERVAL);

      // R5 R6 RAS-only refreshes, with a CBR in between
      do_grant(1'b1);
      wait_idle();
      wait_req();
      do_grant(1'b1);
      wait_idle();
      wait_req();
      do_grant(1'b0);
      wait_idle();
      wait_req();
      do_grant(1'b1);
      wait_idle();

      // R7 R8 saturation
      wait_backlog(MAXB - 1);
      chk("R8 urgent low below limit", urgent, 0);
      wait_backlog(MAXB);
      chk("R8 urgent at limit", urgent, 1);
      chk("R3 request held", req, 1);
      repeat (3 * INTERVAL) step();
      chk("R7 saturated backlog", backlog, MAXB);
      chk("R8 urgent stays", urgent, 1);
      do_grant(1'b0);
      chk("R9 grant retires one", backlog, MAXB - 1);
      chk("R8 urgent drops", urgent, 0);
      wait_idle();
      chk("R9 request again after refresh", req, 1);

      // R9 drain right after a credit arrives
      wait_backlog(MAXB);
      for (int k = 0; k < MAXB; k++) begin
         wait_req();
         do_grant(k[0]);
         chk("R9 drain count", backlog, MAXB - 1 - k);
         wait_idle();
         chk("R9 request between refreshes", req, (k < MAXB - 1));
      end
      chk("R7 empty after drain", backlog, 0);
      step();
      chk("R4 R5 scoreboard empty", exp_q.size(), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule